// File: doc/BRIEF.md
# Paged DMA Channel Controller

This block holds the bookkeeping for a small group of DMA channels and turns each device transfer request into one translated memory request. Every channel owns a control/status word, a remaining byte count and a logical start address, all reachable through a 32-bit register window. When a device asks channel n to move data in a given direction, the block checks the request against the channel's configuration. It limits the length to what the count still allows and looks up the physical page of the logical address in an internal page table. It then updates the count and the status flags of that channel.

The page table holds 4096-byte page frames. Software fills it one entry at a time through an index register and a data register. A byte-sized limit register decides how many entries are valid. The block only issues the physical address, length and channel of a transfer on a one-cycle memory request strobe; data movement and bus arbitration belong to the neighbours.

Top module: `paged_dma_ctrl`

## Requirements
- R1: After reset, every channel register, the table base, the table limit and the error-source register read zero, no memory request is issued and no channel error output is high.
- R2: Channel n's registers sit at byte offset 0x100 + 32*n, with address bits [4:3] choosing the register: 1 = control, 2 = byte count, 3 = logical address, 0 reads zero. Control bit 0 is enable, bit 1 is direction (1 = memory to device), bit 8 is terminal count, bit 9 is memory error, bit 10 is address error. The other control bits are plain storage.
- R3: Every accepted request first clears control bits 8, 9 and 10 of its channel and then leaves exactly one of the three set.
- R4: A request to a channel whose enable bit is 0, or whose direction bit differs from the requested direction, sets the memory-error bit and bit n of the error-source register (offset 0x000). It issues no memory request and leaves the count unchanged.
- R5: A consistent, translatable request issues a memory request in the cycle after it is accepted. Its length is the smaller of the requested length and the count, and its channel field is the requesting channel. The count drops by that length and the terminal-count bit is set.
- R6: The physical address is the frame stored in the table entry selected by logical address bits [31:12], followed by logical address bits [11:0]. Writing offset 0x018 selects the entry index; writing offset 0x01C stores bits [19:0] as that entry's frame. Reading 0x01C returns the selected entry.
- R7: The number of valid entries is the limit register (offset 0x010, in bytes) divided by 8, rounded down and capped at 512. A logical page at or beyond that number sets the address-error bit, issues no memory request and leaves the count unchanged, so a limit of zero makes every request fail this way.
- R8: Output chan_err[n] is high exactly while control bit 9 or bit 10 of channel n is set.
- R9: Error-source bits stay set until reset, and writes to offset 0x000 have no effect.
- R10: The table base (offset 0x008) and the table limit read back the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 9 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| req_valid | input | 1 | Device transfer request strobe |
| req_ch | input | 2 | Requesting channel |
| req_dir | input | 1 | Requested direction, 1 = memory to device |
| req_len | input | 32 | Requested length in bytes |
| mem_valid | output | 1 | Memory request strobe, one cycle |
| mem_paddr | output | 32 | Physical start address |
| mem_len | output | 32 | Granted length in bytes |
| mem_ch | output | 2 | Channel of the memory request |
| chan_err | output | 4 | Per-channel error flag |

## Verification
The embedded assertions watch, on every cycle, that a memory request follows an accepted request and carries no more than the requested length. They also check that an issued channel shows a clean terminal-count status, that each request leaves exactly one status flag set, that a count only grows through a register write, that error-source bits never clear and that an empty table never hits. Only the bench scenarios show the arithmetic itself. These cover the exact clamped length and new count, the frame-plus-offset address for each page, the rounding and capping of the entry count from the byte limit, and the full sweep of enable and direction combinations on every channel.

// File: rtl/paged_dma_pkg.sv
package paged_dma_pkg;
    localparam int CTL_EN   = 0;
    localparam int CTL_DIR  = 1;
    localparam int CTL_TC   = 8;
    localparam int CTL_MERR = 9;
    localparam int CTL_AERR = 10;
    localparam logic [31:0] CTL_FLAGS = 32'h0000_0700;

    localparam int PAGE_SHIFT = 12;
    localparam int FRAME_W    = 32 - PAGE_SHIFT;
    localparam int ENTRY_BYTES_LOG2 = 3;

    localparam logic [8:0] OFS_ESRC  = 9'h000;
    localparam logic [8:0] OFS_BASE  = 9'h008;
    localparam logic [8:0] OFS_LIMIT = 9'h010;
    localparam logic [8:0] OFS_TIDX  = 9'h018;
    localparam logic [8:0] OFS_TDATA = 9'h01C;

    localparam logic [1:0] SLOT_CTRL  = 2'd1;
    localparam logic [1:0] SLOT_COUNT = 2'd2;
    localparam logic [1:0] SLOT_LADDR = 2'd3;
endpackage

// File: rtl/dma_xlate_table.sv
module dma_xlate_table
    import paged_dma_pkg::*;
#(
    parameter int MAX_ENTRIES = 512,
    localparam int IDX_W = $clog2(MAX_ENTRIES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [FRAME_W-1:0] wr_frame,
    output logic [FRAME_W-1:0] rd_frame,
    input  logic [31:0]        limit,
    input  logic [FRAME_W-1:0] page,
    output logic               hit,
    output logic [FRAME_W-1:0] frame
);
    logic [FRAME_W-1:0] entry_q [MAX_ENTRIES];
    logic [31:0] raw_cnt, valid_cnt;

    always_ff @(posedge clk) begin
        if (wr_en) entry_q[wr_idx] <= wr_frame;
    end

    always_comb begin
        raw_cnt   = limit >> ENTRY_BYTES_LOG2;
        valid_cnt = (raw_cnt > 32'(MAX_ENTRIES)) ? 32'(MAX_ENTRIES) : raw_cnt;
        hit       = 32'(page) < valid_cnt;
        frame     = entry_q[page[IDX_W-1:0]];
        rd_frame  = entry_q[wr_idx];
    end

    assert_no_hit_when_off_R7: assert property (@(posedge clk) disable iff (rst)
        (limit == 32'd0) |-> !hit);
endmodule

// File: rtl/dma_req_eval.sv
module dma_req_eval
    import paged_dma_pkg::*;
(
    input  logic [31:0]        ctrl,
    input  logic [31:0]        count,
    input  logic [31:0]        laddr,
    input  logic               req_dir,
    input  logic [31:0]        req_len,
    input  logic               xl_hit,
    input  logic [FRAME_W-1:0] xl_frame,
    output logic [31:0]        ctrl_d,
    output logic [31:0]        count_d,
    output logic               issue,
    output logic               merr,
    output logic [31:0]        paddr,
    output logic [31:0]        len
);
    logic [31:0] cleared;
    logic        consistent;

    always_comb begin
        cleared    = ctrl & ~CTL_FLAGS;
        consistent = ctrl[CTL_EN] && (ctrl[CTL_DIR] == req_dir);
        len        = (req_len < count) ? req_len : count;
        paddr      = {xl_frame, laddr[PAGE_SHIFT-1:0]};
        ctrl_d     = cleared;
        count_d    = count;
        issue      = 1'b0;
        merr       = 1'b0;
        if (!consistent) begin
            ctrl_d[CTL_MERR] = 1'b1;
            merr             = 1'b1;
        end else if (!xl_hit) begin
            ctrl_d[CTL_AERR] = 1'b1;
        end else begin
            ctrl_d[CTL_TC] = 1'b1;
            count_d        = count - len;
            issue          = 1'b1;
        end
    end
endmodule

// File: rtl/paged_dma_ctrl.sv
module paged_dma_ctrl
    import paged_dma_pkg::*;
#(
    parameter int NUM_CH      = 4,
    parameter int MAX_ENTRIES = 512,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int IDX_W = $clog2(MAX_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [8:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              req_valid,
    input  logic [CH_W-1:0]   req_ch,
    input  logic              req_dir,
    input  logic [31:0]       req_len,
    output logic              mem_valid,
    output logic [31:0]       mem_paddr,
    output logic [31:0]       mem_len,
    output logic [CH_W-1:0]   mem_ch,
    output logic [NUM_CH-1:0] chan_err
);
    typedef struct packed {
        logic [NUM_CH-1:0][31:0] ctrl;
        logic [NUM_CH-1:0][31:0] count;
        logic [NUM_CH-1:0][31:0] laddr;
        logic [31:0]             base;
        logic [31:0]             limit;
        logic [IDX_W-1:0]        tidx;
        logic [NUM_CH-1:0]       esrc;
        logic                    mvalid;
        logic [31:0]             mpaddr;
        logic [31:0]             mlen;
        logic [CH_W-1:0]         mch;
    } state_t;

    state_t st_d, st_q;

    // register decode
    logic [2:0]        win_ch;
    logic [1:0]        win_slot;
    logic              win_hit;
    logic [CH_W-1:0]   win_sel;
    logic              tbl_we;
    logic [FRAME_W-1:0] tbl_rd, xl_frame;
    logic              xl_hit;

    always_comb begin
        win_ch   = reg_addr[7:5];
        win_slot = reg_addr[4:3];
        win_hit  = reg_addr[8] && (32'(win_ch) < 32'(NUM_CH));
        win_sel  = win_ch[CH_W-1:0];
        tbl_we   = reg_wr && (reg_addr[8:2] == OFS_TDATA[8:2]);
    end

    // request evaluation against the selected channel
    logic [31:0] ev_ctrl, ev_count, ev_paddr, ev_len;
    logic        ev_issue, ev_merr;

    dma_xlate_table #(.MAX_ENTRIES(MAX_ENTRIES)) u_table (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (tbl_we),
        .wr_idx   (st_q.tidx),
        .wr_frame (reg_wdata[FRAME_W-1:0]),
        .rd_frame (tbl_rd),
        .limit    (st_q.limit),
        .page     (st_q.laddr[req_ch][31:PAGE_SHIFT]),
        .hit      (xl_hit),
        .frame    (xl_frame)
    );

    dma_req_eval u_eval (
        .ctrl     (st_q.ctrl[req_ch]),
        .count    (st_q.count[req_ch]),
        .laddr    (st_q.laddr[req_ch]),
        .req_dir  (req_dir),
        .req_len  (req_len),
        .xl_hit   (xl_hit),
        .xl_frame (xl_frame),
        .ctrl_d   (ev_ctrl),
        .count_d  (ev_count),
        .issue    (ev_issue),
        .merr     (ev_merr),
        .paddr    (ev_paddr),
        .len      (ev_len)
    );

    always_comb begin
        st_d        = st_q;
        st_d.mvalid = 1'b0;
        if (reg_wr) begin
            if (win_hit) begin
                unique case (win_slot)
                    SLOT_CTRL:  st_d.ctrl[win_sel]  = reg_wdata;
                    SLOT_COUNT: st_d.count[win_sel] = reg_wdata;
                    SLOT_LADDR: st_d.laddr[win_sel] = reg_wdata;
                    default: ;
                endcase
            end else if (reg_addr[8:2] == OFS_BASE[8:2]) begin
                st_d.base = reg_wdata;
            end else if (reg_addr[8:2] == OFS_LIMIT[8:2]) begin
                st_d.limit = reg_wdata;
            end else if (reg_addr[8:2] == OFS_TIDX[8:2]) begin
                st_d.tidx = reg_wdata[IDX_W-1:0];
            end
        end
        // a request takes priority over a same-cycle register write
        if (req_valid) begin
            st_d.ctrl[req_ch]  = ev_ctrl;
            st_d.count[req_ch] = ev_count;
            if (ev_merr) st_d.esrc[req_ch] = 1'b1;
            st_d.mvalid = ev_issue;
            st_d.mpaddr = ev_paddr;
            st_d.mlen   = ev_len;
            st_d.mch    = req_ch;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    always_comb begin
        reg_rdata = '0;
        if (win_hit) begin
            unique case (win_slot)
                SLOT_CTRL:  reg_rdata = st_q.ctrl[win_sel];
                SLOT_COUNT: reg_rdata = st_q.count[win_sel];
                SLOT_LADDR: reg_rdata = st_q.laddr[win_sel];
                default:    reg_rdata = '0;
            endcase
        end else begin
            unique case (reg_addr[8:2])
                OFS_ESRC[8:2]:  reg_rdata = 32'(st_q.esrc);
                OFS_BASE[8:2]:  reg_rdata = st_q.base;
                OFS_LIMIT[8:2]: reg_rdata = st_q.limit;
                OFS_TIDX[8:2]:  reg_rdata = 32'(st_q.tidx);
                OFS_TDATA[8:2]: reg_rdata = 32'(tbl_rd);
                default:        reg_rdata = '0;
            endcase
        end
    end

    assign mem_valid = st_q.mvalid;
    assign mem_paddr = st_q.mpaddr;
    assign mem_len   = st_q.mlen;
    assign mem_ch    = st_q.mch;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        assign chan_err[i] = st_q.ctrl[i][CTL_MERR] | st_q.ctrl[i][CTL_AERR];

        assert_one_flag_R3: assert property (@(posedge clk) disable iff (rst)
            ($past(req_valid) && ($past(req_ch) == CH_W'(i)))
            |-> ($countones(st_q.ctrl[i][CTL_AERR:CTL_TC]) == 1));

        assert_count_no_grow_R5: assert property (@(posedge clk) disable iff (rst)
            !$past(reg_wr) |-> (st_q.count[i] <= $past(st_q.count[i])));
    end

    assert_issue_follows_req_R5: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> $past(req_valid));

    assert_issue_len_clamped_R5: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> (mem_len <= $past(req_len)));

    assert_issue_clean_status_R4: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> (st_q.ctrl[mem_ch][CTL_TC] && !chan_err[mem_ch]));

    assert_esrc_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        ((st_q.esrc & $past(st_q.esrc)) == $past(st_q.esrc)));
endmodule

// File: tb/paged_dma_ctrl_test.sv
module paged_dma_ctrl_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [8:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        req_valid = 1'b0;
    logic [1:0]  req_ch = '0;
    logic        req_dir = 1'b0;
    logic [31:0] req_len = '0;
    logic        mem_valid;
    logic [31:0] mem_paddr, mem_len;
    logic [1:0]  mem_ch;
    logic [3:0]  chan_err;

    int vectors = 0;
    int miscompares = 0;

    logic        g_valid;
    logic [31:0] g_paddr, g_len;
    logic [1:0]  g_ch;

    paged_dma_ctrl uut (.*);

    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [8:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic req(input int ch, input logic dir, input logic [31:0] len);
        @(negedge clk);
        req_valid = 1'b1; req_ch = 2'(ch); req_dir = dir; req_len = len;
        @(negedge clk);
        req_valid = 1'b0;
        g_valid = mem_valid; g_paddr = mem_paddr; g_len = mem_len; g_ch = mem_ch;
    endtask

    function automatic logic [8:0] creg(input int ch, input int slot);
        return 9'(32'h100 + ch * 32 + slot * 8);
    endfunction

    function automatic logic [19:0] frame_of(input int i);
        return 20'((32'h40000 + i * 32'h123) & 32'hFFFFF);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++; vectors++;
        $display("FAIL watchdog: got %h expected %h", 32'd1, 32'd0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int ch = 0; ch < 4; ch++) begin
            for (int s = 0; s < 4; s++) begin
                rd(creg(ch, s), v); chk("R1 channel reg", v, 32'd0);
            end
        end
        rd(9'h000, v); chk("R1 error source", v, 0);
        rd(9'h008, v); chk("R1 table base", v, 0);
        rd(9'h010, v); chk("R1 table limit", v, 0);
        chk("R1 mem_valid", 32'(mem_valid), 0);
        chk("R1 chan_err", 32'(chan_err), 0);

        // R10 base/limit storage
        wr(9'h008, 32'hA5A5_1000); rd(9'h008, v); chk("R10 base", v, 32'hA5A5_1000);
        wr(9'h010, 32'd128);       rd(9'h010, v); chk("R10 limit", v, 32'd128);

        // R6 table load and readback
        for (int i = 0; i < 16; i++) begin
            wr(9'h018, 32'(i));
            wr(9'h01C, 32'(frame_of(i)));
        end
        for (int i = 0; i < 16; i += 5) begin
            wr(9'h018, 32'(i)); rd(9'h01C, v); chk("R6 table readback", v, 32'(frame_of(i)));
        end

        // R2 slot 0 reads zero, laddr readback
        wr(creg(3, 0), 32'hFFFF_FFFF); rd(creg(3, 0), v); chk("R2 slot0 zero", v, 0);
        wr(creg(3, 3), 32'h1234_5678); rd(creg(3, 3), v); chk("R2 laddr", v, 32'h1234_5678);

        // R3 R4 R5 R8 consistency sweep
        for (int ch = 0; ch < 4; ch++) begin
            for (int c = 0; c < 8; c++) begin
                logic en, cdir, rdir, ok;
                logic [31:0] cfg;
                en = c[0]; cdir = c[1]; rdir = c[2];
                ok = en && (cdir == rdir);
                cfg = 32'(en) | (32'(cdir) << 1);
                wr(creg(ch, 1), cfg | 32'h700);
                wr(creg(ch, 2), 32'h1000);
                wr(creg(ch, 3), 32'h0000_2034);
                req(ch, rdir, 32'h10);
                rd(creg(ch, 1), v);
                if (ok) begin
                    chk("R3 R5 ctrl after ok", v, cfg | 32'h100);
                    chk("R5 mem_valid", 32'(g_valid), 1);
                    chk("R5 mem_ch", 32'(g_ch), 32'(ch));
                    chk("R5 mem_len", g_len, 32'h10);
                    chk("R6 paddr", g_paddr, {frame_of(2), 12'h034});
                    rd(creg(ch, 2), v); chk("R5 count", v, 32'hFF0);
                    chk("R8 chan_err clear", 32'(chan_err[ch]), 0);
                end else begin
                    chk("R3 R4 ctrl after mismatch", v, cfg | 32'h200);
                    chk("R4 no mem req", 32'(g_valid), 0);
                    rd(creg(ch, 2), v); chk("R4 count kept", v, 32'h1000);
                    rd(9'h000, v); chk("R4 esrc bit", (v >> ch) & 1, 1);
                    chk("R8 chan_err set", 32'(chan_err[ch]), 1);
                end
            end
        end

        // R9 sticky, write ignored
        rd(9'h000, v); chk("R9 esrc all", v, 32'hF);
        wr(9'h000, 32'h0); rd(9'h000, v); chk("R9 esrc write ignored", v, 32'hF);

        // R5 length clamp sweep
        begin
            logic [31:0] counts[5] = '{0, 1, 5, 100, 32'hFFFF};
            logic [31:0] lens[4]   = '{0, 1, 5, 200};
            wr(creg(1, 1), 32'h1);
            wr(creg(1, 3), 32'h0000_5000);
            foreach (counts[a]) begin
                foreach (lens[b]) begin
                    logic [31:0] e;
                    e = (lens[b] < counts[a]) ? lens[b] : counts[a];
                    wr(creg(1, 2), counts[a]);
                    req(1, 1'b0, lens[b]);
                    chk("R5 clamp len", g_len, e);
                    chk("R6 paddr page5", g_paddr, {frame_of(5), 12'h000});
                    rd(creg(1, 2), v); chk("R5 count reduced", v, counts[a] - e);
                    rd(creg(1, 1), v); chk("R5 tc flag", v, 32'h101);
                end
            end
        end

        // R6 R7 translation sweep over limits and pages
        begin
            logic [31:0] lims[5] = '{0, 8, 12, 64, 128};
            wr(creg(2, 1), 32'h3);
            foreach (lims[k]) begin
                int n;
                n = int'(lims[k] / 8);
                if (n > 512) n = 512;
                wr(9'h010, lims[k]);
                for (int p = 0; p < 18; p++) begin
                    logic [31:0] la;
                    la = (32'(p) << 12) | ((32'(p) * 4 + 8) & 32'hFFF);
                    wr(creg(2, 3), la);
                    wr(creg(2, 2), 32'h100);
                    req(2, 1'b1, 32'd4);
                    if (p < n) begin
                        chk("R6 hit valid", 32'(g_valid), 1);
                        chk("R6 hit paddr", g_paddr, {frame_of(p), la[11:0]});
                        rd(creg(2, 2), v); chk("R5 hit count", v, 32'hFC);
                    end else begin
                        chk("R7 miss no req", 32'(g_valid), 0);
                        rd(creg(2, 1), v); chk("R7 addr err flag", v, 32'h403);
                        rd(creg(2, 2), v); chk("R7 miss count kept", v, 32'h100);
                        chk("R8 chan_err addr", 32'(chan_err[2]), 1);
                    end
                end
            end
        end

        // R7 cap at 512 and rounding near the top
        wr(9'h018, 32'd511); wr(9'h01C, 32'(frame_of(511)));
        rd(9'h01C, v); chk("R6 entry 511 readback", v, 32'(frame_of(511)));
        wr(9'h010, 32'd4100);
        wr(creg(2, 3), 32'h001F_F010); wr(creg(2, 2), 32'h100);
        req(2, 1'b1, 32'd4);
        chk("R7 cap page 511 hit", 32'(g_valid), 1);
        chk("R6 page 511 paddr", g_paddr, {frame_of(511), 12'h010});
        wr(creg(2, 3), 32'h0020_0000);
        req(2, 1'b1, 32'd4);
        chk("R7 cap page 512 miss", 32'(g_valid), 0);
        rd(creg(2, 1), v); chk("R7 cap addr err", v, 32'h403);
        wr(9'h010, 32'd4095);
        wr(creg(2, 3), 32'h001F_F010);
        req(2, 1'b1, 32'd4);
        chk("R7 floor 511 entries miss", 32'(g_valid), 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule